// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog for a processor subsystem. Once software sets the run bit, it counts clock ticks. When the count reaches a programmable warning threshold it raises a level interrupt, so software has a last chance to react. When the count reaches a second programmable threshold it drives a fixed-length reset request toward the system reset controller. Software keeps the system alive by writing 1 to the restart register. That write clears the count and the warning.

A sticky cause flag is set by every expiry and is cleared only by the power-on reset. Boot code can therefore tell, after the system has been reset, whether the watchdog caused that reset. A parameter picks one of two register address maps. The bus is a plain single-cycle 32-bit register port with registered read data.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset (`rst_n` low), `warn_irq` and `expire_req` are 0, `rdata` is 0, and the run bit, both thresholds and the cause flag read 0.
- R2: With `ALT_MAP=0` the registers are: restart at 0x04, control at 0x08, status at 0x0C, warning threshold at 0x10, expiry threshold at 0x14.
- R3: With `ALT_MAP=1` the registers are: restart at 0x38, control at 0x40, status at 0x44, warning threshold at 0x4C, expiry threshold at 0x5C. The default-map addresses then read 0.
- R4: Control bit 0 is the run bit. While it is 0 the tick count holds its value and no warning or expiry occurs. Writing 0 also clears `warn_irq`.
- R5: A write to restart with `wdata[0]=1` clears the count, `warn_irq` and the halt left by an expiry. A write with `wdata[0]=0` has no effect.
- R6: While running, the count advances by one per cycle. In the cycle after the count equals the warning threshold, `warn_irq` rises and stays high until a restart or a stop write. It fires at most once between restarts.
- R7: In the cycle after the count equals the expiry threshold, `expire_req` goes high for exactly `EXPIRE_HOLD` (16) cycles. The count is then halted until a restart, and it does not advance while the request is high.
- R8: When both thresholds are equal, `warn_irq` and `expire_req` rise in the same cycle.
- R9: Status bit 0 is set by an expiry and stays set, whatever the bus does, until `rst_n` is asserted.
- R10: A read returns its value on `rdata` after the next clock edge. Threshold registers return the full 32-bit value last written. The control register returns the run bit in bit 0. Restart, unmapped addresses and cycles without a read return 0.
- R11: The count is `CNT_W` (29) bits wide, so it can reach 0x10000000. It stops at all ones rather than wrapping. Thresholds accept any 32-bit value, including 0x10000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous active-low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (8) | Byte address of the register |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid the cycle after `rd_en` |
| warn_irq | output | 1 | Early warning interrupt, level |
| expire_req | output | 1 | Reset request to the system reset controller |

## Verification
Two functions can fall in the same cycle. The warning and the expiry coincide when both thresholds hold the same value. A restart or stop write can also land on the very edge at which the count meets a threshold. The bench makes the first case happen on purpose with equal thresholds, and then requires `warn_irq` and `expire_req` to be seen high together on the first sample where either rises. The second case comes up many times in the random phase, where bus writes are mixed freely with counting. There, a cycle-level reference model that gives restart priority over expiry, and stop priority over the warning, judges every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum int {
    REG_RESTART = 0,
    REG_CTRL    = 1,
    REG_STATUS  = 2,
    REG_WARN    = 3,
    REG_EXPIRE  = 4
  } wdog_reg_e;

  // Byte offset of each register for the two address maps.
  function automatic int wdog_offset(input bit alt_map, input wdog_reg_e r);
    int off;
    if (!alt_map) begin
      case (r)
        REG_RESTART: off = 'h04;
        REG_CTRL:    off = 'h08;
        REG_STATUS:  off = 'h0C;
        REG_WARN:    off = 'h10;
        default:     off = 'h14;
      endcase
    end else begin
      case (r)
        REG_RESTART: off = 'h38;
        REG_CTRL:    off = 'h40;
        REG_STATUS:  off = 'h44;
        REG_WARN:    off = 'h4C;
        default:     off = 'h5C;
      endcase
    end
    return off;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cause_flag,
  output logic              run_q,
  output logic [DATA_W-1:0] warn_thr_q,
  output logic [DATA_W-1:0] exp_thr_q,
  output logic              restart_p,
  output logic              stop_p,
  output logic [DATA_W-1:0] rdata
);

  localparam int OFF_RESTART = wdog_offset(ALT_MAP, REG_RESTART);
  localparam int OFF_CTRL    = wdog_offset(ALT_MAP, REG_CTRL);
  localparam int OFF_STATUS  = wdog_offset(ALT_MAP, REG_STATUS);
  localparam int OFF_WARN    = wdog_offset(ALT_MAP, REG_WARN);
  localparam int OFF_EXPIRE  = wdog_offset(ALT_MAP, REG_EXPIRE);

  logic              hit_restart, hit_ctrl, hit_status, hit_warn, hit_expire;
  logic              run_d;
  logic [DATA_W-1:0] warn_thr_d, exp_thr_d, rd_val, rdata_d;

  always_comb begin
    hit_restart = (addr == ADDR_W'(OFF_RESTART));
    hit_ctrl    = (addr == ADDR_W'(OFF_CTRL));
    hit_status  = (addr == ADDR_W'(OFF_STATUS));
    hit_warn    = (addr == ADDR_W'(OFF_WARN));
    hit_expire  = (addr == ADDR_W'(OFF_EXPIRE));

    restart_p = wr_en & hit_restart & wdata[0];
    stop_p    = wr_en & hit_ctrl & ~wdata[0];

    run_d      = (wr_en & hit_ctrl)   ? wdata[0] : run_q;
    warn_thr_d = (wr_en & hit_warn)   ? wdata    : warn_thr_q;
    exp_thr_d  = (wr_en & hit_expire) ? wdata    : exp_thr_q;

    if (hit_ctrl)        rd_val = DATA_W'(run_q);
    else if (hit_status) rd_val = DATA_W'(cause_flag);
    else if (hit_warn)   rd_val = warn_thr_q;
    else if (hit_expire) rd_val = exp_thr_q;
    else                 rd_val = '0;

    rdata_d = rd_en ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      warn_thr_q <= '0;
      exp_thr_q  <= '0;
      rdata      <= '0;
    end else begin
      run_q      <= run_d;
      warn_thr_q <= warn_thr_d;
      exp_thr_q  <= exp_thr_d;
      rdata      <= rdata_d;
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W  = 29,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic              stop,
  input  logic              hold_busy,
  input  logic [DATA_W-1:0] warn_thr,
  input  logic [DATA_W-1:0] exp_thr,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              warn_q,
  output logic              expire_fire
);

  logic             halt_q, halt_d;
  logic             fired_q, fired_d;
  logic             warn_d;
  logic [CNT_W-1:0] cnt_d;
  logic             active, at_warn, at_exp, at_max;

  always_comb begin
    active  = run & ~halt_q & ~hold_busy;
    at_warn = (DATA_W'(cnt_q) == warn_thr);
    at_exp  = (DATA_W'(cnt_q) == exp_thr);
    at_max  = &cnt_q;

    cnt_d       = cnt_q;
    halt_d      = halt_q;
    fired_d     = fired_q;
    warn_d      = warn_q;
    expire_fire = 1'b0;

    if (restart) begin
      cnt_d   = '0;
      halt_d  = 1'b0;
      fired_d = 1'b0;
      warn_d  = 1'b0;
    end else if (active) begin
      if (at_exp) begin
        halt_d      = 1'b1;
        expire_fire = 1'b1;
      end
      if (at_warn && !fired_q) begin
        warn_d  = 1'b1;
        fired_d = 1'b1;
      end
      if (!at_exp && !at_max) cnt_d = cnt_q + CNT_W'(1);
    end

    if (stop) warn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      halt_q  <= 1'b0;
      fired_q <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      halt_q  <= halt_d;
      fired_q <= fired_d;
      warn_q  <= warn_d;
    end
  end

endmodule

// File: rtl/wdog_expire_ctl.sv
module wdog_expire_ctl #(
  parameter int EXPIRE_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic req,
  output logic cause_q
);

  localparam int HOLD_W = $clog2(EXPIRE_HOLD + 1);

  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              cause_d;

  always_comb begin
    req = (hold_q != '0);
    if (fire)     hold_d = HOLD_W'(EXPIRE_HOLD);
    else if (req) hold_d = hold_q - HOLD_W'(1);
    else          hold_d = hold_q;
    cause_d = cause_q | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      cause_q <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      cause_q <= cause_d;
    end
  end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 29,
  parameter int EXPIRE_HOLD = 16,
  parameter bit ALT_MAP     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              warn_irq,
  output logic              expire_req
);

  logic              run_q, restart_p, stop_p, cause_q, fire;
  logic [DATA_W-1:0] warn_thr_q, exp_thr_q;
  logic [CNT_W-1:0]  cnt_q;

  wdog_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ALT_MAP(ALT_MAP)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .cause_flag(cause_q),
    .run_q     (run_q),
    .warn_thr_q(warn_thr_q),
    .exp_thr_q (exp_thr_q),
    .restart_p (restart_p),
    .stop_p    (stop_p),
    .rdata     (rdata)
  );

  wdog_counter #(
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run_q),
    .restart    (restart_p),
    .stop       (stop_p),
    .hold_busy  (expire_req),
    .warn_thr   (warn_thr_q),
    .exp_thr    (exp_thr_q),
    .cnt_q      (cnt_q),
    .warn_q     (warn_irq),
    .expire_fire(fire)
  );

  wdog_expire_ctl #(
    .EXPIRE_HOLD(EXPIRE_HOLD)
  ) u_exp (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .req    (expire_req),
    .cause_q(cause_q)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W       = 29,
  parameter int EXPIRE_HOLD = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             warn_irq,
  input logic             expire_req,
  input logic             cause_q,
  input logic             restart_p,
  input logic             stop_p,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q
);

  localparam int LW = $clog2(EXPIRE_HOLD + 2);

  logic [LW-1:0] high_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          high_len <= '0;
    else if (expire_req) high_len <= high_len + LW'(1);
    else                 high_len <= '0;
  end

  a_r7_hold_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(expire_req) |-> (high_len == LW'(EXPIRE_HOLD)));

  a_r7_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    expire_req |-> (high_len < LW'(EXPIRE_HOLD)));

  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_req && !restart_p) |=> $stable(cnt_q));

  a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !restart_p) |=> $stable(cnt_q));

  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_p |=> (cnt_q == '0 && !warn_irq));

  a_r6_warn_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_irq) |-> $past(restart_p || stop_p));

  a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q |=> cause_q);

  a_r9_cause_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    expire_req |-> cause_q);

endmodule

bind wdog_two_stage wdog_checker #(
  .CNT_W      (CNT_W),
  .EXPIRE_HOLD(EXPIRE_HOLD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .warn_irq  (warn_irq),
  .expire_req(expire_req),
  .cause_q   (cause_q),
  .restart_p (restart_p),
  .stop_p    (stop_p),
  .run_q     (run_q),
  .cnt_q     (cnt_q)
);

// File: tb/sim_wdog_two_stage.sv
`timescale 1ns/1ps
module sim_wdog_two_stage;

  localparam int          HOLD   = 16;
  localparam logic [28:0] CNTMAX = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        warn_irq, expire_req;

  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic        b_warn, b_exp;

  int nchk = 0, nfail = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  always #10 clk = ~clk;

  wdog_two_stage u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .warn_irq(warn_irq), .expire_req(expire_req)
  );

  wdog_two_stage #(.ALT_MAP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(b_wr), .rd_en(b_rd), .addr(b_addr),
    .wdata(b_wdata), .rdata(b_rdata), .warn_irq(b_warn), .expire_req(b_exp)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reference model, written from the requirements (default map).
  logic        m_run, m_halt, m_warn, m_fired, m_cause, m_restart, m_active, m_fire;
  logic [28:0] m_cnt;
  logic [31:0] m_wthr, m_ethr, m_rdata;
  int          m_hold;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h08:   return {31'b0, m_run};
      8'h0C:   return {31'b0, m_cause};
      8'h10:   return m_wthr;
      8'h14:   return m_ethr;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_halt = 0; m_warn = 0; m_fired = 0; m_cause = 0;
      m_cnt = '0; m_wthr = '0; m_ethr = '0; m_rdata = '0; m_hold = 0;
    end else begin
      m_rdata   = rd_en ? model_read(addr) : 32'h0;
      m_active  = m_run && !m_halt && (m_hold == 0);
      m_restart = wr_en && addr == 8'h04 && wdata[0];
      m_fire    = 1'b0;
      if (m_restart) begin
        m_cnt = '0; m_halt = 0; m_fired = 0; m_warn = 0;
      end else if (m_active) begin
        if ({3'b0, m_cnt} == m_ethr) begin m_fire = 1; m_halt = 1; end
        if ({3'b0, m_cnt} == m_wthr && !m_fired) begin m_warn = 1; m_fired = 1; end
        if ({3'b0, m_cnt} != m_ethr && m_cnt != CNTMAX) m_cnt = m_cnt + 1;
      end
      if (m_fire) begin m_hold = HOLD; m_cause = 1; end
      else if (m_hold != 0) m_hold = m_hold - 1;
      if (wr_en && addr == 8'h08) begin
        m_run = wdata[0];
        if (!wdata[0]) m_warn = 0;
      end
      if (wr_en && addr == 8'h10) m_wthr = wdata;
      if (wr_en && addr == 8'h14) m_ethr = wdata;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      check("R6 warn_irq vs model", {31'b0, warn_irq}, {31'b0, m_warn});
      check("R7 expire_req vs model", {31'b0, expire_req}, {31'b0, (m_hold != 0)});
      check("R10 rdata vs model", rdata, m_rdata);
    end
  end

  // Bus tasks; called at a falling edge, return one falling edge later.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; rd_en = 0; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1; wr_en = 0; addr = a;
    @(negedge clk);
    rd_en = 0;
    check(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_wr_t(input logic [7:0] a, input logic [31:0] d);
    b_wr = 1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_wr = 0;
  endtask

  task automatic b_rd_t(input logic [7:0] a, input logic [31:0] exp, input string tag);
    b_rd = 1; b_addr = a;
    @(negedge clk);
    b_rd = 0;
    check(tag, b_rdata, exp);
  endtask

  task automatic wait_warn(output int n);
    n = 0;
    while (!warn_irq && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: bench did not complete");
    finish_run();
  end

  initial begin
    int n;
    int r;
    void'($urandom(32'd7351));
    idle(4);
    rst_n = 1;
    cmp_on = 1;
    idle(1);

    // R1 reset state
    check("R1 warn_irq after reset", {31'b0, warn_irq}, 32'h0);
    check("R1 expire_req after reset", {31'b0, expire_req}, 32'h0);
    check("R1 rdata after reset", rdata, 32'h0);
    rd(8'h0C, 32'h0, "R1 status after reset");
    rd(8'h08, 32'h0, "R1 control after reset");
    rd(8'h10, 32'h0, "R1 warn thr after reset");

    // R2 / R10 / R11 map and readback
    wr(8'h10, 32'h0001_2345);
    rd(8'h10, 32'h0001_2345, "R2 warn thr at 0x10");
    wr(8'h14, 32'h00AB_CDEF);
    rd(8'h14, 32'h00AB_CDEF, "R2 expiry thr at 0x14");
    rd(8'h04, 32'h0, "R10 restart reads zero");
    rd(8'h18, 32'h0, "R10 unmapped reads zero");
    wr(8'h14, 32'h1000_0000);
    rd(8'h14, 32'h1000_0000, "R11 threshold 0x10000000");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'hFFFF_FFFF, "R11 full-width threshold");

    // R6 warning timing and release
    wr(8'h10, 32'd6);
    wr(8'h14, 32'd30);
    wr(8'h04, 32'd1);
    wr(8'h08, 32'd1);
    rd(8'h08, 32'h1, "R4 control reads run bit");
    wait_warn(n);
    check("R6 warn delay after start", n, 32'd6);
    wr(8'h04, 32'd1);
    check("R6 restart clears warn", {31'b0, warn_irq}, 32'h0);
    wait_warn(n);
    check("R6 warn delay after restart", n, 32'd7);

    // R4 stop
    wr(8'h08, 32'd0);
    check("R4 stop clears warn", {31'b0, warn_irq}, 32'h0);
    idle(40);
    check("R4 no expiry while stopped", {31'b0, expire_req}, 32'h0);
    check("R4 no warn while stopped", {31'b0, warn_irq}, 32'h0);

    // R7 expiry, R6 once per period
    wr(8'h08, 32'd1);
    n = 0;
    while (!expire_req && n < 300) begin @(negedge clk); n++; end
    check("R6 warn does not refire in period", {31'b0, warn_irq}, 32'h0);
    n = 0;
    while (expire_req && n < 100) begin @(negedge clk); n++; end
    check("R7 expiry request length", n, HOLD);
    idle(6);
    check("R7 halted after expiry", {31'b0, expire_req}, 32'h0);
    rd(8'h0C, 32'h1, "R9 cause flag set");

    // R8 equal thresholds
    wr(8'h10, 32'd9);
    wr(8'h14, 32'd9);
    wr(8'h04, 32'd1);
    wait_warn(n);
    check("R8 warn delay", n, 32'd10);
    check("R8 expiry with warn", {31'b0, expire_req}, 32'h1);
    idle(20);

    // R5 restart with bit 0 clear is ignored
    wr(8'h10, 32'd5);
    wr(8'h14, 32'd60);
    wr(8'h04, 32'd1);
    idle(3);
    wr(8'h04, 32'd0);
    wait_warn(n);
    check("R5 zero restart ignored", n + 4, 32'd6);
    rd(8'h0C, 32'h1, "R9 cause survives restart");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h1, "R9 cause survives status write");

    // R9 cleared only by power-on reset
    cmp_on = 0;
    rst_n = 0;
    idle(2);
    rst_n = 1;
    cmp_on = 1;
    idle(1);
    rd(8'h0C, 32'h0, "R9 cause cleared by reset");
    rd(8'h10, 32'h0, "R1 warn thr cleared by reset");

    // R3 alternate map
    b_wr_t(8'h4C, 32'h77);
    b_rd_t(8'h4C, 32'h77, "R3 alt warn thr at 0x4C");
    b_wr_t(8'h5C, 32'h99);
    b_rd_t(8'h5C, 32'h99, "R3 alt expiry thr at 0x5C");
    b_rd_t(8'h10, 32'h0, "R3 default address unmapped");
    b_wr_t(8'h40, 32'h1);
    b_rd_t(8'h40, 32'h1, "R3 alt control at 0x40");
    b_rd_t(8'h44, 32'h0, "R3 alt status at 0x44");
    b_rd_t(8'h08, 32'h0, "R3 default control unmapped");

    // Random phase checked against the model every cycle
    wr(8'h10, 32'd12);
    wr(8'h14, 32'd25);
    wr(8'h08, 32'd1);
    for (int i = 0; i < 4000; i++) begin
      r = $urandom % 100;
      if (r < 3)       wr(8'h04, {31'b0, ($urandom % 5) != 0});
      else if (r < 6)  wr(8'h08, {31'b0, ($urandom % 5) != 0});
      else if (r < 9)  wr(8'h10, $urandom % 48);
      else if (r < 12) wr(8'h14, $urandom % 64);
      else if (r < 40) begin
        rd_en = 1; addr = 8'(($urandom % 8) * 4);
        @(negedge clk);
        rd_en = 0;
      end else idle(1);
    end
    idle(2);
    finish_run();
  end

endmodule